// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter that shares one 8-bit prescaler with a watchdog. An 8-bit option word chooses what the timer counts and which consumer owns the prescaler. The timer can count the instruction-cycle tick or edges on an external pin, and either the rising or the falling edge of that pin can be selected. The option word also holds a 3-bit rate code. The same rate code gives a different division ratio depending on which consumer owns the prescaler. The outputs are the timer value, a one-cycle overflow pulse, and a prescaled tick sent on to the watchdog, which supplies its own base tick.

Ownership of the prescaler is kept in a two-state machine. `OWN_WDT` is the reset state and `OWN_TMR` is the other. The transition "hand to timer" is taken on an option write with bit 3 = 0 while in `OWN_WDT`. The transition "hand to watchdog" is taken on an option write with bit 3 = 1 while in `OWN_TMR`. Any other option write keeps the current state. A handover clears the prescaler count, and so does a bus write to the timer.

The external pin passes through a two-flop synchroniser and then an edge detector. A pin change is therefore reflected in the timer on the third rising clock edge after it.

Top module: `timer0_shared_ps`

## Requirements
- R1: After reset the option word reads FFh, the timer reads 00h, and `tmr_ovf` and `wdt_tick` are low.
- R2: An option write is visible on `opt_q` on the following cycle. Without a write, `opt_q` holds its value. Its bit fields are: bit 5 = source select, bit 4 = edge select, bit 3 = owner, bits 2..0 = rate code.
- R3: The timer wraps from FFh to 00h. `tmr_ovf` is high for exactly the one cycle in which the timer first shows 00h after the wrap.
- R4: With bit 5 = 0 the timer source is `cycle_tick`, and the external pin has no effect. With bit 5 = 1 the source is the external pin, and `cycle_tick` has no effect.
- R5: In external mode, bit 4 = 0 counts low-to-high pin transitions and bit 4 = 1 counts high-to-low transitions. The timer changes on the third rising clock edge after the pin changes.
- R6: With bit 3 = 0, the timer advances once per 2^(rate+1) source events: rate codes 0 to 7 give division by 2 to 256.
- R7: With bit 3 = 1, the timer advances on every source event, and `wdt_tick` pulses once per 2^rate `wdt_base_tick` pulses: rate codes 0 to 7 give division by 1 to 128.
- R8: With bit 3 = 0, every `wdt_base_tick` pulse passes to `wdt_tick` unprescaled.
- R9: A timer write loads `tmr_wdata` on the next cycle, takes priority over a count in the same cycle, and clears the prescaler count.
- R10: An option write that changes bit 3 clears the prescaler count. An option write that leaves bit 3 unchanged does not clear it.
- R11: `wdt_tick` is registered. It rises on the cycle after the `wdt_base_tick` pulse that completes a prescale period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_base_tick | input | 1 | Watchdog base tick, one clock wide |
| opt_wr | input | 1 | Option word write strobe |
| opt_wdata | input | 8 | Option word write data |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| opt_q | output | 8 | Current option word |
| tmr_q | output | 8 | Timer value |
| tmr_ovf | output | 1 | One-cycle pulse when the timer wraps |
| wdt_tick | output | 1 | Prescaled tick sent to the watchdog |

## Verification
The bench builds the block with its defaults: an 8-bit timer, an 8-bit prescaler, a 3-bit rate code and two synchroniser stages. With these values the largest divider, 256, and the wrap from FFh both complete within a few hundred cycles, so the bench drives them to completion rather than inferring them. The two-stage synchroniser sets the pin-to-count latency at exactly three edges, and the bench probes both sides of that boundary. Both ownership transitions are exercised against the owner-independent write that must keep the prescaler count.

// File: rtl/t0_pkg.sv
package t0_pkg;
    typedef enum logic {
        OWN_TMR = 1'b0,
        OWN_WDT = 1'b1
    } own_state_e;

    localparam int OPT_CS_BIT   = 5;
    localparam int OPT_EDGE_BIT = 4;
    localparam int OPT_ASG_BIT  = 3;
endpackage

// File: rtl/t0_pin_sync.sv
module t0_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
    assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/t0_owner_fsm.sv
module t0_owner_fsm
    import t0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_asg,
    output logic owner_wdt,
    output logic handover
);
    own_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OWN_WDT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            OWN_TMR: if (wr && wr_asg)  nxt = OWN_WDT;
            OWN_WDT: if (wr && !wr_asg) nxt = OWN_TMR;
        endcase
    end

    always_comb begin
        owner_wdt = (state == OWN_WDT);
        handover  = (nxt != state);
    end
endmodule

// File: rtl/t0_prescaler.sv
module t0_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    input  logic [PS_W-1:0] mask,
    output logic            match
);
    logic [PS_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign match = ((cnt & mask) == mask);
endmodule

// File: rtl/t0_counter.sv
module t0_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (load) begin
            q   <= ld_val;
            ovf <= 1'b0;
        end else if (inc) begin
            q   <= q + 1'b1;
            ovf <= (q == TOP);
        end else begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/timer0_shared_ps.sv
module timer0_shared_ps
    import t0_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int PS_W        = 8,
    parameter int RATE_W      = 3,
    parameter int OPT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_tick,
    input  logic             ext_pin,
    input  logic             wdt_base_tick,
    input  logic             opt_wr,
    input  logic [OPT_W-1:0] opt_wdata,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    output logic [OPT_W-1:0] opt_q,
    output logic [TMR_W-1:0] tmr_q,
    output logic             tmr_ovf,
    output logic             wdt_tick
);
    localparam logic [PS_W:0] ONE_W = {{PS_W{1'b0}}, 1'b1};

    logic [OPT_W-1:0]  opt_r;
    logic [RATE_W-1:0] rate;
    logic              pin_rise, pin_fall;
    logic              src_ev;
    logic              owner_wdt, handover;
    logic              ps_inc, ps_clr, ps_match;
    logic [PS_W:0]     tmr_mask_w, wdt_mask_w;
    logic [PS_W-1:0]   ps_mask;
    logic              tmr_inc, wdt_fire, wdt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      opt_r <= '1;
        else if (opt_wr) opt_r <= opt_wdata;
    end

    assign rate = opt_r[RATE_W-1:0];

    t0_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(ext_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    t0_owner_fsm u_owner (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (opt_wr),
        .wr_asg   (opt_wdata[OPT_ASG_BIT]),
        .owner_wdt(owner_wdt),
        .handover (handover)
    );

    always_comb begin
        if (opt_r[OPT_CS_BIT]) src_ev = opt_r[OPT_EDGE_BIT] ? pin_fall : pin_rise;
        else                   src_ev = cycle_tick;
    end

    always_comb begin
        tmr_mask_w = (ONE_W << ({1'b0, rate} + 1'b1)) - ONE_W;
        wdt_mask_w = (ONE_W << rate) - ONE_W;
        if (owner_wdt) begin
            ps_mask  = wdt_mask_w[PS_W-1:0];
            ps_inc   = wdt_base_tick;
            tmr_inc  = src_ev;
            wdt_fire = wdt_base_tick & ps_match;
        end else begin
            ps_mask  = tmr_mask_w[PS_W-1:0];
            ps_inc   = src_ev;
            tmr_inc  = src_ev & ps_match;
            wdt_fire = wdt_base_tick;
        end
        ps_clr = tmr_wr | handover;
    end

    t0_prescaler #(.PS_W(PS_W)) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ps_clr),
        .inc  (ps_inc),
        .mask (ps_mask),
        .match(ps_match)
    );

    t0_counter #(.W(TMR_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_wr),
        .ld_val(tmr_wdata),
        .inc   (tmr_inc),
        .q     (tmr_q),
        .ovf   (tmr_ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_q <= 1'b0;
        else        wdt_q <= wdt_fire;
    end

    assign opt_q    = opt_r;
    assign wdt_tick = wdt_q;
endmodule

// File: rtl/timer0_shared_ps_checker.sv
module timer0_shared_ps_checker #(
    parameter int TMR_W = 8,
    parameter int OPT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             opt_wr,
    input logic [OPT_W-1:0] opt_wdata,
    input logic             tmr_wr,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic             wdt_base_tick,
    input logic [OPT_W-1:0] opt_q,
    input logic [TMR_W-1:0] tmr_q,
    input logic             tmr_ovf,
    input logic             wdt_tick,
    input logic             owner_wdt
);
    localparam logic [TMR_W-1:0] TOP = '1;

    p_ovf_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> tmr_q == '0);
    p_ovf_from_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> $past(tmr_q) == TOP);
    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_q == $past(tmr_wdata));
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_q == $past(tmr_q)) || (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));
    p_opt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wr |=> opt_q == $past(opt_wdata));
    p_opt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_wr |=> $stable(opt_q));
    p_wdt_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!opt_q[3] && wdt_base_tick) |=> wdt_tick);
    p_wdt_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick |-> $past(wdt_base_tick));
    p_owner_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
        owner_wdt == opt_q[3]);
endmodule

bind timer0_shared_ps timer0_shared_ps_checker #(.TMR_W(TMR_W), .OPT_W(OPT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .opt_wr       (opt_wr),
    .opt_wdata    (opt_wdata),
    .tmr_wr       (tmr_wr),
    .tmr_wdata    (tmr_wdata),
    .wdt_base_tick(wdt_base_tick),
    .opt_q        (opt_q),
    .tmr_q        (tmr_q),
    .tmr_ovf      (tmr_ovf),
    .wdt_tick     (wdt_tick),
    .owner_wdt    (owner_wdt)
);

// File: tb/timer0_shared_ps_test.sv
module timer0_shared_ps_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_tick = 1'b0, ext_pin = 1'b0, wdt_base_tick = 1'b0;
    logic       opt_wr = 1'b0, tmr_wr = 1'b0;
    logic [7:0] opt_wdata = '0, tmr_wdata = '0;
    logic [7:0] opt_q, tmr_q;
    logic       tmr_ovf, wdt_tick;

    int n_checks = 0, n_err = 0;
    int ovf_seen = 0, wdt_seen = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    // behavioural reference state
    int m_opt, m_tmr, m_ps, m_s1, m_s2, m_prev, m_ovf, m_wdt;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer0_shared_ps uut (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .ext_pin(ext_pin),
        .wdt_base_tick(wdt_base_tick), .opt_wr(opt_wr), .opt_wdata(opt_wdata),
        .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .opt_q(opt_q), .tmr_q(tmr_q),
        .tmr_ovf(tmr_ovf), .wdt_tick(wdt_tick)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_opt = 255; m_tmr = 0; m_ps = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_ovf = 0; m_wdt = 0;
        end else begin
            int own, rt, ev, div, pin_in, base, match, tinc, wfire;
            own  = (m_opt >> 3) & 1;
            rt   = m_opt & 7;
            if (((m_opt >> 5) & 1) == 1)
                ev = (((m_opt >> 4) & 1) == 1) ? int'(m_prev == 1 && m_s2 == 0)
                                               : int'(m_prev == 0 && m_s2 == 1);
            else
                ev = int'(cycle_tick);
            base   = int'(wdt_base_tick);
            pin_in = own ? base : ev;
            div    = own ? (1 << rt) : (2 << rt);
            match  = int'((m_ps % div) == div - 1);
            tinc   = own ? ev : (ev & match);
            wfire  = own ? (base & match) : base;
            if (tmr_wr || (opt_wr && (((int'(opt_wdata) >> 3) & 1) != own))) m_ps = 0;
            else if (pin_in != 0) m_ps = (m_ps + 1) % 256;
            if (tmr_wr) begin m_tmr = int'(tmr_wdata); m_ovf = 0; end
            else if (tinc != 0) begin m_ovf = int'(m_tmr == 255); m_tmr = (m_tmr + 1) % 256; end
            else m_ovf = 0;
            m_wdt = wfire;
            if (opt_wr) m_opt = int'(opt_wdata);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            ovf_seen += int'(tmr_ovf);
            wdt_seen += int'(wdt_tick);
            if (cmp_on) begin
                check("R6 model tmr_q", int'(tmr_q), m_tmr);
                check("R3 model tmr_ovf", int'(tmr_ovf), m_ovf);
                check("R7 model wdt_tick", int'(wdt_tick), m_wdt);
                check("R2 model opt_q", int'(opt_q), m_opt);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic wr_opt(input logic [7:0] v);
        opt_wr = 1'b1; opt_wdata = v; @(negedge clk); opt_wr = 1'b0;
    endtask
    task automatic wr_tmr(input logic [7:0] v);
        tmr_wr = 1'b1; tmr_wdata = v; @(negedge clk); tmr_wr = 1'b0;
    endtask
    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cycle_tick = 1'b1; @(negedge clk); cycle_tick = 1'b0;
            idle(gap);
        end
    endtask
    task automatic bases(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_base_tick = 1'b1; @(negedge clk); wdt_base_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int base_v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 opt_q", int'(opt_q), 'hFF);
        check("R1 tmr_q", int'(tmr_q), 0);
        check("R1 tmr_ovf", int'(tmr_ovf), 0);
        check("R1 wdt_tick", int'(wdt_tick), 0);
        cmp_on = 1'b1;

        // R2 option readback; R6 divide by 2 on timer owner
        wr_opt(8'h00);
        check("R2 opt readback", int'(opt_q), 'h00);
        wr_tmr(8'h00);
        cycle_tick = 1'b1; idle(20); cycle_tick = 1'b0; idle(2);
        check("R6 div2 count", int'(tmr_q), 20 / 2);

        // R6 rate 3: divide by 16, spaced ticks
        wr_opt(8'h03); wr_tmr(8'h00);
        ticks(64, 1); idle(2);
        check("R6 div16 count", int'(tmr_q), 64 / 16);

        // R6 rate 7: divide by 256
        wr_opt(8'h07); wr_tmr(8'h00);
        ticks(255, 0); idle(2);
        check("R6 div256 before", int'(tmr_q), 0);
        ticks(1, 0); idle(2);
        check("R6 div256 after", int'(tmr_q), 1);

        // R9 write overrides count and clears prescaler (div 4)
        wr_opt(8'h01); ticks(2, 0);
        cycle_tick = 1'b1; wr_tmr(8'h40); cycle_tick = 1'b0;
        check("R9 load value", int'(tmr_q), 'h40);
        ticks(3, 0); idle(2);
        check("R9 prescaler cleared", int'(tmr_q), 'h40);
        ticks(1, 0); idle(2);
        check("R9 count resumes", int'(tmr_q), 'h41);

        // R10 same-owner write keeps count, owner switch clears it
        wr_tmr(8'h00); ticks(2, 0);
        wr_opt(8'h01); ticks(2, 0); idle(2);
        check("R10 count kept", int'(tmr_q), 1);
        ticks(2, 0); wr_opt(8'h09); wr_opt(8'h01);
        ticks(2, 0); idle(2);
        check("R10 count cleared", int'(tmr_q), 1);
        ticks(2, 0); idle(2);
        check("R10 after clear", int'(tmr_q), 2);

        // R3 overflow on watchdog owner (timer counts every tick)
        wr_opt(8'h08); wr_tmr(8'hFE);
        ovf_seen = 0;
        cycle_tick = 1'b1;
        @(negedge clk);
        check("R3 reach FF", int'(tmr_q), 'hFF);
        check("R3 no early ovf", int'(tmr_ovf), 0);
        @(negedge clk);
        cycle_tick = 1'b0;
        check("R3 wrap to 00", int'(tmr_q), 0);
        check("R3 ovf pulse", int'(tmr_ovf), 1);
        @(negedge clk);
        check("R3 ovf one cycle", int'(tmr_ovf), 0);
        check("R3 single pulse", ovf_seen, 1);

        // R4/R5 external rising edge, latency 3
        wr_opt(8'h28); wr_tmr(8'h00);
        ticks(10, 0); idle(2);
        check("R4 cycle_tick ignored", int'(tmr_q), 0);
        ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 not before edge 3", int'(tmr_q), 0);
        @(negedge clk);
        check("R5 counted at edge 3", int'(tmr_q), 1);
        ext_pin = 1'b0; idle(4);
        check("R5 falling ignored", int'(tmr_q), 1);
        for (int i = 0; i < 4; i++) begin
            ext_pin = 1'b1; idle(3); ext_pin = 1'b0; idle(3);
        end
        idle(2);
        check("R5 rising count", int'(tmr_q), 5);

        // R5 falling edge
        wr_opt(8'h38); wr_tmr(8'h00);
        ext_pin = 1'b1; idle(5);
        check("R5 rising ignored", int'(tmr_q), 0);
        ext_pin = 1'b0; idle(5);
        check("R5 falling counted", int'(tmr_q), 1);

        // R4 internal mode ignores pin
        wr_opt(8'h08); base_v = int'(tmr_q);
        ext_pin = 1'b1; idle(4); ext_pin = 1'b0; idle(4);
        check("R4 pin ignored", int'(tmr_q), base_v);

        // R7 watchdog owner division
        wr_opt(8'h0A); wr_tmr(8'h00); idle(2);
        wdt_seen = 0;
        bases(16); idle(2);
        check("R7 div4 pulses", wdt_seen, 16 / 4);
        wr_opt(8'h08); idle(2); wdt_seen = 0;
        bases(5); idle(2);
        check("R7 div1 pulses", wdt_seen, 5);

        // R8 timer owner passes base tick unprescaled
        wr_opt(8'h07); idle(2); wdt_seen = 0;
        bases(5); idle(2);
        check("R8 direct pulses", wdt_seen, 5);

        // R11 registered timing
        wr_opt(8'h08); idle(1);
        wdt_base_tick = 1'b1;
        @(negedge clk);
        wdt_base_tick = 1'b0;
        check("R11 rises after base", int'(wdt_tick), 1);
        @(negedge clk);
        check("R11 one cycle", int'(wdt_tick), 0);

        idle(4);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule